// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Handshake

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock when the write enable is high and the write-side status pin shows room. They leave through a registered output on the read clock. Each side keeps a binary pointer one bit wider than the storage address. The pointer crosses into the other clock domain as a Gray code through a two-stage synchronizer, so every status pin is derived in the clock domain of the port it belongs to.

Two handshake flavours share the same two status pins. The flavour is latched from a mode input while reset is active.

- **Standard mode.** The read-side pin is an active-low empty flag: high means a word can be read. A read enable moves the next word into the output register.
- **Fall-through mode.** The read-side pin means output-ready. The oldest word moves into the output register by itself, and a read enable consumes the word shown. The output register therefore adds one word of capacity.

In both modes the write-side pin is an active-low full flag, or input-ready: high means a location is free.

A word written into an empty buffer becomes visible after two read-clock edges in standard mode and after three in fall-through mode. A location freed by a read becomes writable again after two write-clock edges.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is active and right after it, `rd_avail` is 0, `wr_room` is 1 and `rd_data` is all zeros; both pointers are cleared.
- R2: `flag_mode` (0 = standard, 1 = fall-through) is captured only while reset is active; changing it after reset release does not change the handshake behaviour.
- R3: In standard mode, after a write into an empty buffer, `rd_avail` is still 0 after the first rising `rclk` edge and is 1 after the second; `rd_data` does not change until a read is accepted.
- R4: In standard mode, a read enable while `rd_avail` is 1 loads the oldest word into `rd_data` on that edge; a read enable while `rd_avail` is 0 is ignored and `rd_data` holds.
- R5: In fall-through mode, after a write into an empty buffer, `rd_avail` is 0 after the first and second rising `rclk` edges; the third edge sets `rd_avail` to 1 and loads the word into `rd_data`, with no read enable needed.
- R6: In fall-through mode, a read enable while `rd_avail` is 1 consumes the shown word: on that edge the next word appears, or `rd_avail` drops to 0 if the memory is empty. A read enable while `rd_avail` is 0 is ignored and `rd_data` holds.
- R7: `wr_room` goes to 0 on the edge of the write that fills the buffer. The buffer is full at DEPTH words in standard mode, and at DEPTH words in memory plus one in the output register in fall-through mode. A write enable while `wr_room` is 0 is ignored.
- R8: After a read frees a location in a full buffer, `wr_room` is still 0 after the first rising `wclk` edge and is 1 after the second.
- R9: Words leave in the order they were written, including across pointer wrap-around.
- R10: Each pointer crosses domains as a Gray code: between consecutive clocks of its own domain at most one bit of the crossing value changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| flag_mode | input | 1 | Handshake select sampled during reset: 0 standard, 1 fall-through |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| wr_room | output | 1 | High when a location is free (active-low full / input-ready) |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read data |
| rd_avail | output | 1 | Standard: high when data can be read (active-low empty). Fall-through: output-ready |

## Verification
The bench builds the block with DEPTH = 4 and WIDTH = 8. This small depth puts the full condition within four writes, so the full-to-not-full latency can be measured directly. It also lets the group-wise vector walk wrap both pointers past the extra Gray bit. Both clocks run at the same rate with a fixed phase offset, so each synchronizer latency can be counted edge by edge. This is how the two-edge versus three-edge visibility difference between the modes is pinned down.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    HS_STANDARD = 1'b0,
    HS_FALLTHRU = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  output logic          wr_room,
  output logic          wr_acc,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray
);
  logic [AW:0] wbin_q, wbin_d;
  logic [AW:0] wgray_q, wgray_d;
  logic [AW:0] full_pat;
  logic        is_full;

  assign full_pat = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
  assign is_full  = (wgray_q == full_pat);
  assign wr_room  = ~is_full;
  assign wr_acc   = wr_en & ~is_full;

  always_comb begin
    wbin_d  = wbin_q;
    if (wr_acc) begin
      wbin_d = wbin_q + 1'b1;
    end
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;

  // R10
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  // R7
  full_hold_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && !wr_room) |=> $stable(wgray_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AW    = 4
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             mode_i,
  input  logic             rd_en,
  input  logic [AW:0]      wgray_s,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic             rd_avail,
  output logic [WIDTH-1:0] rdata
);
  hs_mode_e         mode_q;
  logic [AW:0]      rbin_q, rbin_d;
  logic [AW:0]      rgray_q, rgray_d;
  logic             ordy_q, ordy_d;
  logic [WIDTH-1:0] rdata_q, rdata_d;
  logic             mem_empty;
  logic             load;

  // Mode register: enabled only while the domain reset is held.
  always_ff @(posedge rclk) begin
    if (!rrst_n) begin
      mode_q <= hs_mode_e'(mode_i);
    end
  end

  assign mem_empty = (rgray_q == wgray_s);

  always_comb begin
    if (mode_q == HS_FALLTHRU) begin
      load     = ~mem_empty & (~ordy_q | rd_en);
      ordy_d   = load | (ordy_q & ~rd_en);
      rd_avail = ordy_q;
    end else begin
      load     = rd_en & ~mem_empty;
      ordy_d   = 1'b0;
      rd_avail = ~mem_empty;
    end
    rbin_d  = load ? rbin_q + 1'b1 : rbin_q;
    rgray_d = rbin_d ^ (rbin_d >> 1);
    rdata_d = load ? mem_rdata : rdata_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ordy_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      ordy_q  <= ordy_d;
      rdata_q <= rdata_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
  assign rdata = rdata_q;

  // R10
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);

  // R10
  wsync_step_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(wgray_s ^ $past(wgray_s)) <= 1);

  // R4
  std_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_q == HS_STANDARD && rd_en && !rd_avail) |=> $stable(rdata_q));

  // R5
  fwft_load_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_q == HS_FALLTHRU && $rose(ordy_q)) |-> (rbin_q != $past(rbin_q)));

  // R6
  fwft_idle_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (mode_q == HS_FALLTHRU && !ordy_q && mem_empty) |=> $stable(rdata_q));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             rst_n,
  input  logic             flag_mode,
  input  logic             wclk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_room,
  input  logic             rclk,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_avail
);
  logic          wrst_n, rrst_n;
  logic          wr_acc;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [WIDTH-1:0] mem_rdata;

  dcf_sync #(.W(1)) wrst_sync_i (
    .clk(wclk), .arst_n(rst_n), .d(1'b1), .q(wrst_n));

  dcf_sync #(.W(1)) rrst_sync_i (
    .clk(rclk), .arst_n(rst_n), .d(1'b1), .q(rrst_n));

  dcf_sync #(.W(AW+1)) w2r_sync_i (
    .clk(rclk), .arst_n(rrst_n), .d(wgray), .q(wgray_s));

  dcf_sync #(.W(AW+1)) r2w_sync_i (
    .clk(wclk), .arst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcf_wr_ctl #(.AW(AW)) wr_ctl_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wr_room(wr_room), .wr_acc(wr_acc), .waddr(waddr), .wgray(wgray));

  dcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) mem_i (
    .wclk(wclk), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  dcf_rd_ctl #(.WIDTH(WIDTH), .AW(AW)) rd_ctl_i (
    .rclk(rclk), .rrst_n(rrst_n), .mode_i(flag_mode), .rd_en(rd_en),
    .wgray_s(wgray_s), .mem_rdata(mem_rdata), .raddr(raddr),
    .rgray(rgray), .rd_avail(rd_avail), .rdata(rd_data));
endmodule

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  // stimulus [15:8], expected read data [7:0]
  localparam logic [15:0] VEC [8] = '{16'hA5A5, 16'h5A5A, 16'h0101, 16'hFEFE,
                                      16'h3333, 16'hC3C3, 16'h7E7E, 16'h1818};

  logic         wclk, rclk, rst_n, flag_mode, wr_en, rd_en, wr_room, rd_avail;
  logic [W-1:0] wr_data, rd_data;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 0;

  dcf_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .rst_n(rst_n), .flag_mode(flag_mode), .wclk(wclk), .wr_en(wr_en),
    .wr_data(wr_data), .wr_room(wr_room), .rclk(rclk), .rd_en(rd_en),
    .rd_data(rd_data), .rd_avail(rd_avail));

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #2; forever #5 rclk = ~rclk; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge wclk); wr_en = 1'b1; wr_data = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; flag_mode = mode; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge wclk);
    chk("R1 rd_avail in reset", rd_avail, 0);
    chk("R1 wr_room in reset", wr_room, 1);
    chk("R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge wclk);
    flag_mode = ~mode;  // R2: must not take effect
    chk("R1 rd_avail after release", rd_avail, 0);
    chk("R1 wr_room after release", wr_room, 1);
    repeat (2) @(negedge rclk);
  endtask

  initial begin
    repeat (20000) @(posedge wclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    wr(8'h3C);
    @(negedge rclk); chk("R3 std flag after 1 edge", rd_avail, 0);
    @(negedge rclk); chk("R3 std flag after 2 edges", rd_avail, 1);
    chk("R3 std data not moved without read", rd_data, 0);
    chk("R2 mode change after reset ignored", rd_data, 0);
    rd();
    chk("R4 std read data", rd_data, 8'h3C);
    chk("R4 std empty after read", rd_avail, 0);
    rd();
    chk("R4 std read on empty holds data", rd_data, 8'h3C);

    // Table walk: two groups of DEPTH, the second wraps the pointers (R9 R10)
    for (int g = 0; g < 2; g++) begin
      for (int j = 0; j < D; j++) wr(VEC[g*D+j][15:8]);
      chk("R7 std full after DEPTH writes", wr_room, 0);
      wr(8'hEE);
      chk("R7 std full holds after ignored write", wr_room, 0);
      repeat (3) @(negedge rclk);
      for (int j = 0; j < D; j++) begin
        rd();
        chk("R9 R10 order across wrap", rd_data, {24'h0, VEC[g*D+j][7:0]});
      end
      chk("R7 ignored write absent", rd_avail, 0);
      repeat (4) @(negedge wclk);
    end

    // Full release latency
    for (int j = 0; j < D; j++) wr(8'h51 + W'(j));
    chk("R7 std full again", wr_room, 0);
    repeat (3) @(negedge rclk);
    rd();
    chk("R4 std first of block", rd_data, 8'h51);
    @(negedge wclk); chk("R8 room after 1 wclk edge", wr_room, 0);
    @(negedge wclk); chk("R8 room after 2 wclk edges", wr_room, 1);
    for (int j = 1; j < D; j++) begin
      rd();
      chk("R9 std block order", rd_data, 32'(8'h51 + j));
    end

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    wr(8'h77);
    @(negedge rclk); chk("R5 fwft flag after 1 edge", rd_avail, 0);
    @(negedge rclk); chk("R5 fwft flag after 2 edges", rd_avail, 0);
    chk("R2 mode held despite input change", rd_avail, 0);
    chk("R5 fwft data not yet loaded", rd_data, 0);
    @(negedge rclk); chk("R5 fwft flag after 3 edges", rd_avail, 1);
    chk("R5 fwft data loaded on third edge", rd_data, 8'h77);
    rd();
    chk("R6 fwft consume empties", rd_avail, 0);
    chk("R6 fwft data holds", rd_data, 8'h77);
    rd();
    chk("R6 fwft read while not ready ignored", rd_data, 8'h77);
    chk("R6 fwft still not ready", rd_avail, 0);

    wr(8'h81);
    repeat (4) @(negedge rclk);
    chk("R5 fwft fell through", rd_data, 8'h81);
    repeat (4) @(negedge wclk);
    for (int j = 0; j < D; j++) wr(8'h82 + W'(j));
    chk("R7 fwft full at DEPTH+1", wr_room, 0);
    wr(8'h99);
    chk("R7 fwft full after ignored write", wr_room, 0);
    repeat (3) @(negedge rclk);
    for (int j = 0; j < D; j++) begin
      rd();
      chk("R6 fwft next word shown", rd_data, 32'(8'h82 + j));
      chk("R6 fwft ready while words remain", rd_avail, 1);
    end
    rd();
    chk("R7 fwft ignored write absent", rd_avail, 0);
    chk("R6 fwft last word holds", rd_data, 8'h85);

    done = 1;
    report();
    $finish;
  end
endmodule